// File: doc/BRIEF.md
# Serial Peripheral Chip-Select Sequencer

This block drives the active-low chip-select lines of a serial peripheral master. The transfer controller supplies a select code and a request strobe. The block turns the code into a line pattern, in one of two ways. In decoded mode, the lowest zero bit of the code names the one line to pull low. In raw mode, the code bits are copied to the lines as they are. The code comes either from a fixed setting or from a per-transfer source, chosen by an input.

When the block moves from one active pattern to a different one, it first drives every line high for a guard gap. This stops two devices from driving the bus at the same moment. The gap is set in clock cycles and has a floor of six cycles. A ready flag is low while the gap runs. A deselect input releases all lines and starts the gap. A decoded code of all ones selects no device and raises an error flag.

Top module: `spi_csel_gen`

## Requirements
- R1: With `raw_mode`=0, the select code is decoded by its lowest zero bit: code xxx0 gives `cs_n`=1110, xx01 gives 1101, x011 gives 1011, and 0111 gives 0111. At most one line is ever low in this mode.
- R2: With `raw_mode`=0, code 1111 selects no line. The lines go or stay all high, and `code_err` reads 1 from the cycle after the request. Any later accepted request with a valid code clears `code_err`. A request is accepted when `chg_req`=1 and `desel`=0.
- R3: With `raw_mode`=1, the target pattern equals the code bit for bit. `code_err` reads 0 after such a request, even for code 1111.
- R4: When `xfer_src`=1, the code is taken from `xfer_code` and `fix_code` has no effect. When `xfer_src`=0, the code is taken from `fix_code`.
- R5: A request for a different pattern while a line is low does two things in the next cycle: it drives all lines high, and it starts a gap. The new pattern appears after exactly `guard_cyc` all-high cycles when `guard_cyc` is greater than 6. Lines never change directly from one low pattern to another.
- R6: When `guard_cyc` is 6 or less, the gap is exactly 6 cycles.
- R7: A request whose pattern equals the present `cs_n` changes nothing: no gap, and `ready` stays 1. A request made while all lines are high and no gap runs takes effect in the next cycle.
- R8: `ready` is 0 for every cycle of a gap, and all lines are high then. It returns to 1 in the same cycle the new pattern is driven.
- R9: While reset is held, `cs_n` is all ones, `ready` is 1 and `code_err` is 0.
- R10: `desel`=1 while a line is low drives all lines high in the next cycle and starts a full gap. During a gap, `desel` cancels any pending pattern and takes priority over `chg_req`.
- R11: A request made during a gap replaces the pending pattern without restarting the gap. A request for all-high cancels it. When the gap ends, the most recent pending pattern is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fix_code | input | CS_W | Fixed select code |
| raw_mode | input | 1 | 1: code copied to lines; 0: lowest-zero decode |
| xfer_src | input | 1 | 1: use the per-transfer code instead of the fixed one |
| xfer_code | input | CS_W | Per-transfer select code |
| guard_cyc | input | GAP_W | Guard gap length in cycles (floor of MIN_GAP) |
| chg_req | input | 1 | Request to drive the pattern of the current code |
| desel | input | 1 | Release all lines and start the guard gap |
| cs_n | output | CS_W | Active-low chip-select lines |
| ready | output | 1 | Low while a guard gap runs |
| code_err | output | 1 | Last accepted decoded request used the forbidden code |

## Verification
The bench measures the all-high window between two patterns at guard settings below, at and above the floor. A wrong floor or an off-by-one counter would show up as a gap of 5, 7 or the raw setting. It sends same-pattern requests, which a careless design would answer with a needless gap. It also sends requests in the middle of a gap, where a design could keep a stale target or restart the count. Deselect is mixed with requests in the same cycle to expose a wrong priority. The forbidden code is sent in both modes, since raising the error in raw mode, or driving a line for it, is a likely slip.

// File: rtl/csel_pkg.sv
package csel_pkg;
  // Smallest guard gap the sequencer will ever produce, in cycles.
  localparam int unsigned GAP_FLOOR = 6;
  // Stages in the reset release synchronizer.
  localparam int unsigned RST_STAGES = 2;
endpackage

// File: rtl/csel_rst_sync.sv
module csel_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/csel_decode.sv
module csel_decode #(
  parameter int unsigned CS_W = 4
) (
  input  logic [CS_W-1:0] code_i,
  input  logic            raw_i,
  output logic [CS_W-1:0] pat_o,
  output logic            bad_o
);
  logic found;

  always_comb begin
    pat_o = '1;
    found = 1'b0;
    bad_o = 1'b0;
    if (raw_i) begin
      pat_o = code_i;
    end else begin
      for (int i = 0; i < CS_W; i++) begin
        if (!found && !code_i[i]) begin
          pat_o[i] = 1'b0;
          found    = 1'b1;
        end
      end
      bad_o = !found;
    end
  end

  // R1: decoded mode never selects more than one line
  always_comb begin
    if (!raw_i) a_r1_single_line: assert ($countones(~pat_o) <= 1);
  end
endmodule

// File: rtl/csel_gap_timer.sv
module csel_gap_timer #(
  parameter int unsigned GAP_W   = 8,
  parameter int unsigned MIN_GAP = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [GAP_W-1:0] guard_i,
  output logic             busy_o,
  output logic             expire_o
);
  localparam logic [GAP_W-1:0] FLOOR = GAP_W'(MIN_GAP);

  logic [GAP_W-1:0] cnt_q, cnt_d, load_len;
  logic             busy_q, busy_d;
  logic             cnt_en;

  assign load_len = (guard_i < FLOOR) ? FLOOR : guard_i;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (start_i) begin
      busy_d = 1'b1;
      cnt_d  = load_len - 1'b1;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_d = 1'b0;
      else             cnt_d  = cnt_q - 1'b1;
    end
  end

  assign cnt_en = start_i | busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assign busy_o   = busy_q;
  assign expire_o = busy_q && (cnt_q == '0);

  // R6: a started gap never holds fewer than the floor count
  a_r6_floor_load: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (busy_q && (cnt_q >= FLOOR - 1'b1)));
  // R5: the count only falls while a gap runs
  a_r5_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !start_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/spi_csel_gen.sv
module spi_csel_gen #(
  parameter int unsigned CS_W    = 4,
  parameter int unsigned GAP_W   = 8,
  parameter int unsigned MIN_GAP = csel_pkg::GAP_FLOOR
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CS_W-1:0]  fix_code,
  input  logic             raw_mode,
  input  logic             xfer_src,
  input  logic [CS_W-1:0]  xfer_code,
  input  logic [GAP_W-1:0] guard_cyc,
  input  logic             chg_req,
  input  logic             desel,
  output logic [CS_W-1:0]  cs_n,
  output logic             ready,
  output logic             code_err
);
  localparam logic [CS_W-1:0] ALL_HI = '1;

  logic            rst_sync_n;
  logic [CS_W-1:0] src_code, tgt_pat;
  logic            tgt_bad;
  logic            busy, expire, start_gap;
  logic [CS_W-1:0] cs_q, cs_d, pend_q, pend_d;
  logic            pv_q, pv_d, err_q, err_d;
  logic            accept;

  csel_rst_sync #(.STAGES(csel_pkg::RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  assign src_code = xfer_src ? xfer_code : fix_code;

  csel_decode #(.CS_W(CS_W)) u_dec (
    .code_i(src_code), .raw_i(raw_mode), .pat_o(tgt_pat), .bad_o(tgt_bad));

  csel_gap_timer #(.GAP_W(GAP_W), .MIN_GAP(MIN_GAP)) u_gap (
    .clk(clk), .rst_n(rst_sync_n), .start_i(start_gap), .guard_i(guard_cyc),
    .busy_o(busy), .expire_o(expire));

  assign accept = chg_req && !desel;

  always_comb begin
    cs_d      = cs_q;
    pend_d    = pend_q;
    pv_d      = pv_q;
    err_d     = err_q;
    start_gap = 1'b0;
    if (accept) err_d = tgt_bad;
    if (busy) begin
      if (desel) begin
        pv_d = 1'b0;
      end else if (chg_req) begin
        pv_d   = (tgt_pat != ALL_HI);
        pend_d = tgt_pat;
      end
      if (expire) begin
        cs_d = pv_d ? pend_d : ALL_HI;
        pv_d = 1'b0;
      end
    end else if (desel) begin
      if (cs_q != ALL_HI) begin
        cs_d      = ALL_HI;
        start_gap = 1'b1;
      end
    end else if (chg_req && (tgt_pat != cs_q)) begin
      if (cs_q == ALL_HI) begin
        cs_d = tgt_pat;
      end else begin
        cs_d      = ALL_HI;
        start_gap = 1'b1;
        pv_d      = (tgt_pat != ALL_HI);
        pend_d    = tgt_pat;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cs_q   <= ALL_HI;
      pend_q <= ALL_HI;
      pv_q   <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      cs_q  <= cs_d;
      pv_q  <= pv_d;
      err_q <= err_d;
      if (pv_d) pend_q <= pend_d;
    end
  end

  assign cs_n     = cs_q;
  assign ready    = !busy;
  assign code_err = err_q;

  // R5: no direct move between two different low patterns
  a_r5_no_swap: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cs_n != ALL_HI) |=> ((cs_n == $past(cs_n)) || (cs_n == ALL_HI)));
  // R8: lines are all high while ready is low
  a_r8_quiet_gap: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !ready |-> (cs_n == ALL_HI));
  // R2: a forbidden decoded code leaves every line released
  a_r2_no_select: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (accept && !busy && tgt_bad) |=> ((cs_n == ALL_HI) && code_err));
  // R7: a request for the present pattern keeps lines and ready steady
  a_r7_same_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (accept && !busy && (tgt_pat == cs_n)) |=> ($stable(cs_n) && ready));
endmodule

// File: tb/spi_csel_gen_test.sv
module spi_csel_gen_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] fix_code, xfer_code;
  logic       raw_mode, xfer_src, chg_req, desel;
  logic [7:0] guard_cyc;
  logic [3:0] cs_n;
  logic       ready, code_err;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  logic [3:0] m_cs, m_pend;
  logic       m_run, m_pv, m_err;
  int         m_cnt;

  always #5 clk = ~clk;

  spi_csel_gen uut (
    .clk(clk), .rst_n(rst_n), .fix_code(fix_code), .raw_mode(raw_mode),
    .xfer_src(xfer_src), .xfer_code(xfer_code), .guard_cyc(guard_cyc),
    .chg_req(chg_req), .desel(desel), .cs_n(cs_n), .ready(ready),
    .code_err(code_err));

  function automatic logic [4:0] ref_decode(logic [3:0] c, logic raw);
    if (raw) return {1'b0, c};
    casez (c)
      4'b???0: return 5'b0_1110;
      4'b??01: return 5'b0_1101;
      4'b?011: return 5'b0_1011;
      4'b0111: return 5'b0_0111;
      default: return 5'b1_1111;
    endcase
  endfunction

  function automatic int gap_len(logic [7:0] g);
    return (g <= 8'd6) ? 6 : int'(g);
  endfunction

  task automatic model_reset();
    m_cs = 4'hF; m_pend = 4'hF; m_run = 0; m_pv = 0; m_err = 0; m_cnt = 0;
  endtask

  task automatic model_update();
    logic [4:0] d;
    logic [3:0] tgt;
    d = ref_decode(xfer_src ? xfer_code : fix_code, raw_mode);
    tgt = d[3:0];
    if (chg_req && !desel) m_err = d[4];
    if (m_run) begin
      if (desel) m_pv = 0;
      else if (chg_req) begin m_pv = (tgt != 4'hF); m_pend = tgt; end
      if (m_cnt == 0) begin
        m_run = 0; m_cs = m_pv ? m_pend : 4'hF; m_pv = 0;
      end else m_cnt--;
    end else if (desel) begin
      if (m_cs != 4'hF) begin m_cs = 4'hF; m_run = 1; m_cnt = gap_len(guard_cyc) - 1; end
    end else if (chg_req && tgt != m_cs) begin
      if (m_cs == 4'hF) m_cs = tgt;
      else begin
        m_cs = 4'hF; m_run = 1; m_cnt = gap_len(guard_cyc) - 1;
        m_pv = (tgt != 4'hF); m_pend = tgt;
      end
    end
  endtask

  task automatic chk(string tag, logic [3:0] act, logic [3:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic step(string tag);
    @(posedge clk);
    model_update();
    @(negedge clk);
    chk({tag, " cs_n"}, cs_n, m_cs);
    chk({tag, " ready"}, {3'b0, ready}, {3'b0, !m_run});
    chk({tag, " code_err"}, {3'b0, code_err}, {3'b0, m_err});
  endtask

  task automatic request(logic [3:0] c, logic raw, string tag);
    fix_code = c; raw_mode = raw; chg_req = 1;
    step(tag);
    chg_req = 0;
    for (int i = 0; i < 300 && !ready; i++) step(tag);
  endtask

  task automatic measure(logic [3:0] c, logic [7:0] g, string tag);
    int n = 0;
    guard_cyc = g; fix_code = c; raw_mode = 0; chg_req = 1;
    step(tag);
    chg_req = 0;
    while (cs_n == 4'hF && n < 300) begin
      n++;
      chk({tag, " ready low in gap"}, {3'b0, ready}, 4'd0);
      step(tag);
    end
    chk({tag, " gap length"}, 4'(n), 4'(gap_len(g)));
    chk({tag, " ready with new lines"}, {3'b0, ready}, 4'd1);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      nfail++; nchk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4021));
    rst_n = 0; fix_code = 0; xfer_code = 0; raw_mode = 0; xfer_src = 0;
    chg_req = 0; desel = 0; guard_cyc = 8'd0;
    model_reset();
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 cs_n", cs_n, 4'hF);
    chk("R9 ready", {3'b0, ready}, 4'd1);
    chk("R9 code_err", {3'b0, code_err}, 4'd0);
    rst_n = 1;
    repeat (4) step("R9 idle");

    // R1: decode of each lowest-zero position
    request(4'b1010, 0, "R1"); chk("R1 xxx0", cs_n, 4'b1110);
    request(4'b0101, 0, "R1"); chk("R1 xx01", cs_n, 4'b1101);
    request(4'b0011, 0, "R1"); chk("R1 x011", cs_n, 4'b1011);
    request(4'b0111, 0, "R1"); chk("R1 0111", cs_n, 4'b0111);
    // R2: forbidden code
    request(4'b1111, 0, "R2"); chk("R2 lines", cs_n, 4'hF);
    chk("R2 err set", {3'b0, code_err}, 4'd1);
    request(4'b1000, 0, "R2"); chk("R2 err cleared", {3'b0, code_err}, 4'd0);
    // R3: raw mode
    request(4'b0101, 1, "R3"); chk("R3 raw", cs_n, 4'b0101);
    request(4'b1111, 1, "R3"); chk("R3 raw ones no err", {3'b0, code_err}, 4'd0);
    // R4: per-transfer source
    xfer_src = 1; xfer_code = 4'b1101;
    request(4'b0000, 0, "R4"); chk("R4 xfer code used", cs_n, 4'b1101);
    xfer_src = 0;
    // R7: same pattern, no gap
    request(4'b1101, 0, "R7"); chk("R7 same", cs_n, 4'b1101);
    fix_code = 4'b1101; chg_req = 1; step("R7");
    chg_req = 0;
    chk("R7 no gap", {3'b0, ready}, 4'd1);
    chk("R7 lines held", cs_n, 4'b1101);
    // R5 / R6: gap length
    measure(4'b0011, 8'd0,  "R6 g0");
    measure(4'b0111, 8'd6,  "R6 g6");
    measure(4'b1110, 8'd7,  "R5 g7");
    measure(4'b1101, 8'd20, "R5 g20");
    // R10: deselect then request
    guard_cyc = 8'd9;
    desel = 1; fix_code = 4'b1110; chg_req = 1; step("R10");
    desel = 0; chg_req = 0;
    chk("R10 released", cs_n, 4'hF);
    chk("R10 gap started", {3'b0, ready}, 4'd0);
    for (int i = 0; i < 8; i++) step("R10 gap");
    chk("R10 still high", cs_n, 4'hF);
    step("R10 end");
    chk("R10 pending cancelled", cs_n, 4'hF);
    chk("R10 ready back", {3'b0, ready}, 4'd1);
    request(4'b1110, 0, "R7 idle"); chk("R7 idle immediate", cs_n, 4'b1110);
    // R11: retarget during gap
    guard_cyc = 8'd8;
    fix_code = 4'b1101; chg_req = 1; step("R11");
    fix_code = 4'b0011; step("R11");
    chg_req = 0;
    for (int i = 0; i < 300 && !ready; i++) step("R11");
    chk("R11 latest target", cs_n, 4'b1011);

    // random phase, model compared every cycle (R1/R2/R3/R4/R5/R6/R7/R8/R10/R11)
    for (int k = 0; k < 4000; k++) begin
      fix_code  = 4'($urandom);
      xfer_code = 4'($urandom);
      raw_mode  = ($urandom % 4) == 0;
      xfer_src  = ($urandom % 4) == 0;
      chg_req   = ($urandom % 4) == 0;
      desel     = ($urandom % 16) == 0;
      guard_cyc = 8'($urandom % 13);
      step("R5/R8 random");
    end
    chg_req = 0; desel = 0;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule